// File: doc/BRIEF.md
# Embedded-Clock Frame Serializer

This block turns one 24-bit pixel word per pixel period into a 28-bit serial frame sent one bit per bit-clock cycle, the bit clock running at 28 times the pixel rate. Each word is bit-permuted, XOR-scrambled with an additive LFSR keystream and then DC-balanced by conditional inversion against a running disparity. Four overhead bits are then added. A fixed 1 start bit and a fixed 0 stop bit give the far end one guaranteed rising edge per frame, from which it recovers the clock.

Alongside the serial bit, the block drives an output-enable for the line driver and a per-bit emphasis flag. The driver is enabled only while data-enable, power-down-bar and PLL lock are all high. Dropping data-enable only silences the driver and leaves framing running. Power-down or loss of lock discards the link state, and a fresh lock edge is needed before frames resume.

Top module: `emb_clk_serializer`

## Requirements
- R1: Every frame is 28 bits long and is sent one bit per `clk_i` cycle, bit 0 first. Bit 0 is 1. Bits 1..24 carry the encoded word, LSB first. Bit 25 is the inversion flag. Bits 26 and 27 are 0.
- R2: Before scrambling, the payload is permuted: permuted bit i equals `payload_i[(7*i) mod 24]`.
- R3: The permuted word is XORed with a keystream from a 15-bit LFSR s (polynomial x^15+x^14+1). For i = 0..23, in order, the feedback f = s[14]^s[13] becomes key bit i and s shifts to {s[13:0], f}. The state carries over from frame to frame and is 15'h2A5B for the first frame after lock.
- R4: Let d = 2*ones-24 be the disparity of the scrambled word, and let the running disparity start at 0 for the first frame after lock. The word is inverted, with flag 1, when d and the running disparity are both nonzero and of equal sign. The running disparity then adds the disparity of the word actually sent, and it never leaves -24..+24.
- R5: `oe_o` is high only while `den_i`, `pwdn_ni` and `lock_i` are all high and a frame has been loaded since lock. It falls in the same cycle that any of those inputs falls.
- R6: While `den_i` is low, framing, scrambler and disparity keep advancing. When `den_i` rises again, output resumes on the continuing sequence with no relock.
- R7: A rising edge of `lock_i` while `pwdn_ni` is high establishes lock. The start bit of the first frame appears after the second rising `clk_i` edge counted from the edge that samples the lock rise.
- R8: After `pwdn_ni` goes low, a `lock_i` that stays high across power-up does not re-establish lock. Only a new rising edge of `lock_i` does.
- R9: `emph_o` is high during a bit whose value differs from the previous serial bit. It is low on repeated bits and whenever `oe_o` is low. The serial bit before the first frame counts as 0.
- R10: Losing lock mid-frame stops the frame. The next lock restarts the LFSR from the seed and the running disparity from 0.
- R11: Under reset, `ser_o`, `oe_o` and `emph_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock, 28x pixel rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwdn_ni | input | 1 | Power-down-bar; low stops the link |
| den_i | input | 1 | Driver enable |
| lock_i | input | 1 | PLL lock indication |
| payload_i | input | 24 | Pixel word, sampled once per frame |
| ser_o | output | 1 | Serial bit |
| oe_o | output | 1 | Line driver output enable |
| emph_o | output | 1 | Pre-emphasis flag for the current bit |

## Verification
A lock rise applied before an edge is sampled at that edge. The frame loads one edge later, and bit k of that frame is on `ser_o` after k further edges. Each frame therefore spans exactly 28 edges, and the payload for the next frame must be applied before the edge that follows bit 27. The bench sets each payload at the falling edge just after bit 27 and reads every bit, enable and emphasis value at falling edges. Enable gating is combinational in the control inputs, so the bench checks it at the falling edge at which the input changes. It confirms that relock waits for a fresh lock edge by holding `lock_i` high through power-up for more than one frame time.

// File: rtl/ecs_pkg.sv
package ecs_pkg;
  localparam int unsigned PAY_W_DEF   = 24;
  localparam int unsigned OVH_W       = 4;
  localparam int unsigned LFSR_W_DEF  = 15;
  localparam int unsigned TAP_HI_DEF  = 14;
  localparam int unsigned TAP_LO_DEF  = 13;
  localparam int unsigned STRIDE_DEF  = 7;
  localparam logic [LFSR_W_DEF-1:0] SEED_DEF = 15'h2A5B;
endpackage

// File: rtl/ecs_lock_ctrl.sv
module ecs_lock_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwdn_ni,
  input  logic lock_i,
  output logic locked_o
);
  logic lock_d_q, locked_q;
  logic lock_rise;

  assign lock_rise = lock_i & ~lock_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_d_q <= 1'b0;
      locked_q <= 1'b0;
    end else begin
      lock_d_q <= lock_i;
      if (!pwdn_ni || !lock_i) locked_q <= 1'b0;
      else if (lock_rise)      locked_q <= 1'b1;
    end
  end

  assign locked_o = locked_q;

  // R8
  pwdn_unlock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwdn_ni |=> !locked_q);

  // R7
  lock_needs_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!locked_q && !(lock_i && !lock_d_q)) |=> !locked_q);
endmodule

// File: rtl/ecs_encoder.sv
module ecs_encoder #(
  parameter int unsigned PAY_W  = 24,
  parameter int unsigned LFSR_W = 15,
  parameter int unsigned TAP_HI = 14,
  parameter int unsigned TAP_LO = 13,
  parameter int unsigned STRIDE = 7,
  parameter logic [LFSR_W-1:0] SEED = 15'h2A5B,
  localparam int unsigned FRAME_W = PAY_W + 4,
  localparam int unsigned RD_W = $clog2(PAY_W) + 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic               load_i,
  input  logic [PAY_W-1:0]   payload_i,
  output logic [FRAME_W-1:0] frame_o
);
  logic [PAY_W-1:0]  perm, keys, scr, word;
  logic [LFSR_W-1:0] lfsr_q, lfsr_n;
  logic signed [RD_W-1:0] rd_q;
  logic [RD_W-1:0]   rd_n;
  logic              inv;

  // fixed bit permutation (randomize stage)
  for (genvar gi = 0; gi < PAY_W; gi++) begin : g_perm
    assign perm[gi] = payload_i[(gi*STRIDE) % PAY_W];
  end

  // keystream: one LFSR step per payload bit
  always_comb begin
    logic [LFSR_W-1:0] s;
    logic fb;
    s = lfsr_q;
    keys = '0;
    for (int i = 0; i < int'(PAY_W); i++) begin
      fb = s[TAP_HI] ^ s[TAP_LO];
      keys[i] = fb;
      s = {s[LFSR_W-2:0], fb};
    end
    lfsr_n = s;
  end

  assign scr = perm ^ keys;

  always_comb begin
    int d, r;
    d = 2 * $countones(scr) - int'(PAY_W);
    r = int'(rd_q);
    inv = ((r > 0) && (d > 0)) || ((r < 0) && (d < 0));
    rd_n = RD_W'(inv ? r - d : r + d);
  end

  assign word    = inv ? ~scr : scr;
  assign frame_o = {1'b0, 1'b0, inv, word, 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lfsr_q <= SEED;
      rd_q   <= '0;
    end else if (!run_i) begin
      lfsr_q <= SEED;
      rd_q   <= '0;
    end else if (load_i) begin
      lfsr_q <= lfsr_n;
      rd_q   <= rd_n;
    end
  end

  // R4
  rd_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(rd_q) <= int'(PAY_W)) && (int'(rd_q) >= -int'(PAY_W)));

  // R3
  lfsr_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_q != '0);

  // R10
  seed_on_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (lfsr_q == SEED) && (rd_q == 0));
endmodule

// File: rtl/ecs_shifter.sv
module ecs_shifter #(
  parameter int unsigned FRAME_W = 28,
  localparam int unsigned CNT_W = $clog2(FRAME_W),
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               load_o,
  output logic               active_o,
  output logic [CNT_W-1:0]   phase_o,
  output logic               ser_o,
  output logic               prev_o
);
  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-1:0] sh_q;
  logic               active_q, prev_q;

  assign load_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= LAST;
      sh_q     <= '0;
      active_q <= 1'b0;
      prev_q   <= 1'b0;
    end else begin
      prev_q <= sh_q[0];
      if (!run_i) begin
        cnt_q    <= LAST;
        sh_q     <= '0;
        active_q <= 1'b0;
      end else if (load_o) begin
        cnt_q    <= '0;
        sh_q     <= frame_i;
        active_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        sh_q  <= sh_q >> 1;
      end
    end
  end

  assign active_o = active_q;
  assign phase_o  = cnt_q;
  assign ser_o    = sh_q[0];
  assign prev_o   = prev_q;

  // R1
  phase_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);

  // R1
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && cnt_q == LAST) |=> (cnt_q == '0) || !$past(run_i));
endmodule

// File: rtl/emb_clk_serializer.sv
module emb_clk_serializer
  import ecs_pkg::*;
#(
  parameter int unsigned PAY_W  = PAY_W_DEF,
  parameter int unsigned LFSR_W = LFSR_W_DEF,
  parameter int unsigned TAP_HI = TAP_HI_DEF,
  parameter int unsigned TAP_LO = TAP_LO_DEF,
  parameter int unsigned STRIDE = STRIDE_DEF,
  parameter logic [LFSR_W-1:0] SEED = SEED_DEF,
  localparam int unsigned FRAME_W = PAY_W + OVH_W,
  localparam int unsigned CNT_W = $clog2(FRAME_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwdn_ni,
  input  logic             den_i,
  input  logic             lock_i,
  input  logic [PAY_W-1:0] payload_i,
  output logic             ser_o,
  output logic             oe_o,
  output logic             emph_o
);
  logic               locked, load, active, prev;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   phase;

  ecs_lock_ctrl i_lock (
    .clk_i, .rst_ni, .pwdn_ni, .lock_i,
    .locked_o (locked)
  );

  ecs_encoder #(
    .PAY_W(PAY_W), .LFSR_W(LFSR_W), .TAP_HI(TAP_HI), .TAP_LO(TAP_LO),
    .STRIDE(STRIDE), .SEED(SEED)
  ) i_enc (
    .clk_i, .rst_ni,
    .run_i     (locked),
    .load_i    (load),
    .payload_i (payload_i),
    .frame_o   (frame)
  );

  ecs_shifter #(.FRAME_W(FRAME_W)) i_shift (
    .clk_i, .rst_ni,
    .run_i    (locked),
    .frame_i  (frame),
    .load_o   (load),
    .active_o (active),
    .phase_o  (phase),
    .ser_o    (ser_o),
    .prev_o   (prev)
  );

  assign oe_o   = active & den_i & pwdn_ni & lock_i;
  assign emph_o = oe_o & (ser_o ^ prev);

  // R1
  start_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && phase == '0) |-> ser_o);

  // R1
  stop_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && phase == CNT_W'(FRAME_W - 1)) |-> !ser_o);

  // R5
  oe_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_o |-> locked);

  // R9
  emph_repeat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_o == $past(ser_o)) |-> !emph_o);
endmodule

// File: tb/test_emb_clk_serializer.sv
module test_emb_clk_serializer;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pwdn_ni = 1'b1, den_i = 1'b1, lock_i = 1'b0;
  logic [23:0] payload_i = '0;
  logic ser_o, oe_o, emph_o;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [14:0] m_lfsr;
  int          m_rd;
  logic        m_prev;
  logic [23:0] m_keys;

  always #2.5 clk = ~clk;

  emb_clk_serializer i_emb_clk_serializer (
    .clk_i(clk), .rst_ni, .pwdn_ni, .den_i, .lock_i, .payload_i,
    .ser_o, .oe_o, .emph_o
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // model of R2..R4 (frame layout per R1)
  task automatic model_frame(input logic [23:0] p, output logic [27:0] f);
    logic [23:0] x;
    int ones, d;
    logic inv;
    for (int i = 0; i < 24; i++) x[i] = p[(7 * i) % 24];
    for (int i = 0; i < 24; i++) begin
      m_keys[i] = m_lfsr[14] ^ m_lfsr[13];
      m_lfsr = {m_lfsr[13:0], m_keys[i]};
    end
    x = x ^ m_keys;
    ones = 0;
    for (int i = 0; i < 24; i++) ones += int'(x[i]);
    d = 2 * ones - 24;
    inv = (d != 0) && (m_rd != 0) && ((d > 0) == (m_rd > 0));
    if (inv) begin x = ~x; d = -d; end
    m_rd += d;
    f = {2'b00, inv, x, 1'b1};
  endtask

  task automatic model_reset();
    m_lfsr = 15'h2A5B;
    m_rd   = 0;
    m_prev = 1'b0;
  endtask

  // called at a negedge just before the load edge
  task automatic run_frame(input logic [23:0] p, input bit exp_oe, input string tag);
    logic [27:0] exp_f, got_f;
    logic [23:0] w, dec;
    bit oe_ok = 1, emph_ok = 1;
    logic bad_oe = 0, bad_emph = 0;
    payload_i = p;
    model_frame(p, exp_f);
    for (int b = 0; b < 28; b++) begin
      logic e;
      @(posedge clk); @(negedge clk);
      got_f[b] = ser_o;
      e = exp_oe & (ser_o ^ m_prev);
      m_prev = ser_o;
      if (oe_o !== exp_oe) begin oe_ok = 0; bad_oe = oe_o; end
      if (emph_o !== e) begin emph_ok = 0; bad_emph = emph_o; end
    end
    chk(got_f === exp_f, "R1/R2/R3/R4", {tag, " frame"}, 32'(got_f), 32'(exp_f));
    chk(oe_ok, "R5", {tag, " oe"}, 32'(bad_oe), 32'(exp_oe));
    chk(emph_ok, "R9", {tag, " emph"}, 32'(bad_emph), 32'(~bad_emph));
    // far-end model: undo balance, scramble and permutation
    w = got_f[25] ? ~got_f[24:1] : got_f[24:1];
    w = w ^ m_keys;
    for (int i = 0; i < 24; i++) dec[(7 * i) % 24] = w[i];
    chk(dec === p, "R2", {tag, " decode"}, 32'(dec), 32'(p));
    chk(m_rd <= 24 && m_rd >= -24, "R4", {tag, " disparity"}, 32'(m_rd), 32'd24);
  endtask

  // R7: lock rise, then one edge to lock, one to load
  task automatic start_link();
    @(negedge clk); lock_i = 1'b0;
    repeat (2) @(negedge clk);
    lock_i = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(oe_o == 1'b0 && ser_o == 1'b0, "R7", "no frame before load edge", 32'(oe_o), 32'd0);
    model_reset();
  endtask

  task automatic t_reset();
    #1;
    chk(ser_o == 1'b0, "R11", "ser in reset", 32'(ser_o), 0);
    chk(oe_o == 1'b0, "R11", "oe in reset", 32'(oe_o), 0);
    chk(emph_o == 1'b0, "R11", "emph in reset", 32'(emph_o), 0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_ni = 1'b1;
  endtask

  task automatic t_frames();
    start_link();
    run_frame(24'h000000, 1, "zeros");
    run_frame(24'hFFFFFF, 1, "ones");
    run_frame(24'hAAAAAA, 1, "alt");
    run_frame(24'h123456, 1, "mix");
    run_frame(24'h000000, 1, "zeros2");
    run_frame(24'hC0FFEE, 1, "mix2");
  endtask

  task automatic t_den();
    den_i = 1'b0;
    #0.1;
    chk(oe_o == 1'b0, "R5", "oe falls with den", 32'(oe_o), 0);
    run_frame(24'h55AA55, 0, "R6 den low");
    run_frame(24'h0F0F0F, 0, "R6 den low2");
    den_i = 1'b1;
    run_frame(24'h314159, 1, "R6 resume");
    run_frame(24'h271828, 1, "R6 resume2");
  endtask

  task automatic t_lock_loss();
    payload_i = 24'h777777;
    repeat (10) @(negedge clk);
    lock_i = 1'b0;
    #0.1;
    chk(oe_o == 1'b0, "R5", "oe falls with lock", 32'(oe_o), 0);
    chk(emph_o == 1'b0, "R9", "emph low without oe", 32'(emph_o), 0);
    start_link();
    run_frame(24'hABCDEF, 1, "R10 relock");
    run_frame(24'h000001, 1, "R10 relock2");
  endtask

  task automatic t_pwdn();
    bit stayed_off = 1;
    repeat (5) @(negedge clk);
    pwdn_ni = 1'b0;
    #0.1;
    chk(oe_o == 1'b0, "R5", "oe falls with pwdn", 32'(oe_o), 0);
    repeat (5) @(negedge clk);
    pwdn_ni = 1'b1;
    for (int c = 0; c < 60; c++) begin
      @(negedge clk);
      if (oe_o !== 1'b0) stayed_off = 0;
    end
    chk(stayed_off, "R8", "stale lock keeps driver off", 32'(stayed_off), 1);
    start_link();
    run_frame(24'h800000, 1, "R8 after relock");
    run_frame(24'hFEDCBA, 1, "R8 after relock2");
  endtask

  initial begin
    t_reset();
    t_frames();
    t_den();
    t_lock_loss();
    t_pwdn();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule